// File: doc/BRIEF.md
# Double-Precision Floating-Point Compare Unit

This unit compares two IEEE-754 binary64 operands, A and B, and produces a one-hot 4-bit condition code. Each compare writes the code into one 4-bit field of a 32-bit condition register and into a separate 4-bit result-class field. The destination field is picked by a 3-bit index that arrives with the request. A NaN on either input makes the result unordered. In that case the unit may also raise sticky invalid-operation flags, and the code is still written.

A mode input chooses between the unordered and the ordered flavour of the compare. Both modes produce the same code. They differ only in the flags raised for NaN inputs. The unordered flavour flags only signaling NaNs. The ordered flavour also flags a compare whose only NaNs are quiet. A request is one cycle of `start`. The registers and a one-cycle `done` pulse update on the next clock edge.

Top module: `fp_compare_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `cond_reg`, `fprf`, `done`, `flag_snan` and `flag_vc` all become zero.
- R2: For non-NaN operands the code is 4'b1000 when A < B, 4'b0100 when A > B and 4'b0010 when A == B, using the real numeric order. This holds across signs, for two negatives, and for infinities.
- R3: A NaN operand is one with an all-ones exponent and a nonzero fraction. When A or B is a NaN, the code is 4'b0001 (unordered).
- R4: +0 and -0 compare equal (4'b0010) in either operand order.
- R5: Field k of `cond_reg` occupies bits [31-4k : 28-4k], and `field_idx` selects k. A compare writes only the selected field. The other seven fields, and the whole register when `start` is low, keep their values.
- R6: Every compare loads `fprf` with the same code it writes into the condition-register field.
- R7: A signaling NaN has fraction bit 51 equal to 0, and a quiet NaN has it equal to 1. In unordered mode (`ordered`=0), `flag_snan` is set only when the result is unordered and an operand is a signaling NaN. A quiet-NaN-only compare raises no flag, and the code is still written.
- R8: In ordered mode (`ordered`=1) with an unordered result, a signaling-NaN operand sets `flag_snan` and not `flag_vc`. A compare whose only NaNs are quiet sets `flag_vc`.
- R9: The flags are sticky until `flag_clr` is high at a clock edge. If the same edge also completes a compare that raises a flag, that flag ends set.
- R10: `done` is high for exactly the one cycle after each cycle in which `start` is high, and the registers change in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle compare request |
| ordered | input | 1 | 1 selects the ordered compare, 0 the unordered compare |
| opa | input | 64 | Operand A, binary64 |
| opb | input | 64 | Operand B, binary64 |
| field_idx | input | 3 | Destination condition-register field |
| flag_clr | input | 1 | Clears the sticky flags |
| cond_reg | output | 32 | Condition register, eight 4-bit fields |
| fprf | output | 4 | Result-class field of the status register |
| done | output | 1 | Pulse marking a register update |
| flag_snan | output | 1 | Sticky invalid flag for a signaling NaN |
| flag_vc | output | 1 | Sticky invalid flag for an ordered compare of quiet NaNs |

## Verification
A flag clear and a flag-raising compare can complete on the same clock edge. The bench first leaves both flags set. It then drives `flag_clr` together with an ordered quiet-NaN compare in one cycle. The expected result is `flag_vc` set, because the new event wins, and `flag_snan` cleared. In the same cycle the condition-register field must still receive 4'b0001.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int FW     = 64;
    localparam int EXPW   = 11;
    localparam int FRACW  = 52;
    localparam int NFIELD = 8;
    localparam int CCW    = 4;
    localparam int IDXW   = $clog2(NFIELD);
    localparam int CRW    = NFIELD * CCW;
    localparam int MAGW   = FW - 1;

    typedef enum logic [CCW-1:0] {
        CC_LT = 4'b1000,
        CC_GT = 4'b0100,
        CC_EQ = 4'b0010,
        CC_UN = 4'b0001
    } cc_t;

    typedef struct packed {
        logic            is_nan;
        logic            is_snan;
        logic            is_zero;
        logic            sign;
        logic [MAGW-1:0] mag;
    } opclass_t;

    typedef struct packed {
        cc_t  cc;
        logic snan_seen;
    } cmp_res_t;

    function automatic opclass_t classify(input logic [FW-1:0] v);
        opclass_t c;
        logic exp_ones;
        logic frac_nz;
        exp_ones  = &v[FW-2 -: EXPW];
        frac_nz   = |v[FRACW-1:0];
        c.sign    = v[FW-1];
        c.mag     = v[MAGW-1:0];
        c.is_nan  = exp_ones && frac_nz;
        c.is_snan = exp_ones && frac_nz && !v[FRACW-1];
        c.is_zero = (v[MAGW-1:0] == '0);
        return c;
    endfunction
endpackage

// File: rtl/fp_classify.sv
module fp_classify
    import fcmp_pkg::*;
(
    input  logic [FW-1:0] op,
    output opclass_t      cls
);
    always_comb cls = classify(op);
endmodule

// File: rtl/fp_order.sv
module fp_order
    import fcmp_pkg::*;
(
    input  opclass_t ca,
    input  opclass_t cb,
    output cmp_res_t res
);
    logic a_less;

    always_comb begin
        a_less = 1'b0;
        res.snan_seen = ca.is_snan || cb.is_snan;
        if (ca.is_nan || cb.is_nan) begin
            res.cc = CC_UN;
        end else if (ca.is_zero && cb.is_zero) begin
            res.cc = CC_EQ;
        end else if (ca.sign != cb.sign) begin
            res.cc = ca.sign ? CC_LT : CC_GT;
        end else if (ca.mag == cb.mag) begin
            res.cc = CC_EQ;
        end else begin
            a_less = ca.sign ? (ca.mag > cb.mag) : (ca.mag < cb.mag);
            res.cc = a_less ? CC_LT : CC_GT;
        end
    end
endmodule

// File: rtl/cr_update.sv
module cr_update
    import fcmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            ordered,
    input  logic [IDXW-1:0] field_idx,
    input  logic            flag_clr,
    input  cmp_res_t        res,
    output logic [CRW-1:0]  cond_reg,
    output logic [CCW-1:0]  fprf,
    output logic            done,
    output logic            flag_snan,
    output logic            flag_vc
);
    logic unord;
    assign unord = (res.cc == CC_UN);

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_reg  <= '0;
            fprf      <= '0;
            done      <= 1'b0;
            flag_snan <= 1'b0;
            flag_vc   <= 1'b0;
        end else begin
            done <= start;
            if (flag_clr) begin
                flag_snan <= 1'b0;
                flag_vc   <= 1'b0;
            end
            if (start) begin
                fprf <= res.cc;
                for (int k = 0; k < NFIELD; k++) begin
                    if (field_idx == IDXW'(k))
                        cond_reg[CRW-CCW*(k+1) +: CCW] <= res.cc;
                end
                if (unord && res.snan_seen)
                    flag_snan <= 1'b1;
                else if (unord && ordered)
                    flag_vc <= 1'b1;
            end
        end
    end

    // R10
    done_follow_chk: assert property (@(posedge clk) disable iff (rst) start |=> done);
    // R6
    fprf_onehot_chk: assert property (@(posedge clk) disable iff (rst) done |-> $countones(fprf) == 1);
    // R5
    cr_hold_chk: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(cond_reg));
    // R7
    snan_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_snan) |-> $past(start) && $past(res.snan_seen) && $past(res.cc == CC_UN));
    // R8
    vc_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_vc) |-> $past(start) && $past(ordered) && !$past(res.snan_seen));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !start) |=> (!flag_snan && !flag_vc));
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
    import fcmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            ordered,
    input  logic [FW-1:0]   opa,
    input  logic [FW-1:0]   opb,
    input  logic [IDXW-1:0] field_idx,
    input  logic            flag_clr,
    output logic [CRW-1:0]  cond_reg,
    output logic [CCW-1:0]  fprf,
    output logic            done,
    output logic            flag_snan,
    output logic            flag_vc
);
    opclass_t cls_a, cls_b;
    cmp_res_t res;

    fp_classify u_cls_a (.op(opa), .cls(cls_a));
    fp_classify u_cls_b (.op(opb), .cls(cls_b));
    fp_order    u_order (.ca(cls_a), .cb(cls_b), .res(res));

    cr_update u_upd (
        .clk(clk), .rst(rst), .start(start), .ordered(ordered),
        .field_idx(field_idx), .flag_clr(flag_clr), .res(res),
        .cond_reg(cond_reg), .fprf(fprf), .done(done),
        .flag_snan(flag_snan), .flag_vc(flag_vc)
    );

    // R3
    nan_unord_chk: assert property (@(posedge clk) disable iff (rst)
        (start && (cls_a.is_nan || cls_b.is_nan)) |=> fprf == 4'b0001);
endmodule

// File: tb/sim_fp_compare_unit.sv
module sim_fp_compare_unit;
    localparam time PERIOD = 10ns;

    localparam logic [63:0] P1   = 64'h3FF0000000000000;
    localparam logic [63:0] P2   = 64'h4000000000000000;
    localparam logic [63:0] N1   = 64'hBFF0000000000000;
    localparam logic [63:0] N2   = 64'hC000000000000000;
    localparam logic [63:0] PZ   = 64'h0000000000000000;
    localparam logic [63:0] NZ   = 64'h8000000000000000;
    localparam logic [63:0] PINF = 64'h7FF0000000000000;
    localparam logic [63:0] NINF = 64'hFFF0000000000000;
    localparam logic [63:0] QNAN = 64'h7FF8000000000000;
    localparam logic [63:0] SNAN = 64'h7FF0000000000001;

    logic        clk = 0;
    logic        rst = 1;
    logic        start = 0, ordered = 0, flag_clr = 0;
    logic [63:0] opa = '0, opb = '0;
    logic [2:0]  field_idx = '0;
    logic [31:0] cond_reg;
    logic [3:0]  fprf;
    logic        done, flag_snan, flag_vc;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] exp_cr  = '0;

    always #(PERIOD/2) clk = ~clk;

    fp_compare_unit u0 (
        .clk(clk), .rst(rst), .start(start), .ordered(ordered),
        .opa(opa), .opb(opb), .field_idx(field_idx), .flag_clr(flag_clr),
        .cond_reg(cond_reg), .fprf(fprf), .done(done),
        .flag_snan(flag_snan), .flag_vc(flag_vc)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input logic [2:0] idx,
                          input logic mode, input logic clr, input logic [3:0] code, input string req);
        @(negedge clk);
        opa = a; opb = b; field_idx = idx; ordered = mode; start = 1; flag_clr = clr;
        @(negedge clk);
        start = 0; flag_clr = 0;
        exp_cr[31-4*idx -: 4] = code;
        check({req, " code"}, 64'(fprf), 64'(code));
        check("R5 field", 64'(cond_reg), 64'(exp_cr));
        check("R10 done", 64'(done), 64'd1);
        check("R6 fprf matches field", 64'(fprf), 64'(cond_reg[31-4*idx -: 4]));
    endtask

    task automatic t_reset();
        check("R1 cond_reg", 64'(cond_reg), 64'd0);
        check("R1 fprf", 64'(fprf), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 flags", 64'({flag_snan, flag_vc}), 64'd0);
    endtask

    task automatic t_order();
        do_cmp(P1, P2, 3'd0, 0, 0, 4'b1000, "R2 1<2");
        do_cmp(P2, P1, 3'd7, 0, 0, 4'b0100, "R2 2>1");
        do_cmp(N2, N1, 3'd3, 1, 0, 4'b1000, "R2 -2<-1");
        do_cmp(N1, N2, 3'd4, 0, 0, 4'b0100, "R2 -1>-2");
        do_cmp(N1, P1, 3'd5, 0, 0, 4'b1000, "R2 -1<1");
        do_cmp(PINF, P2, 3'd6, 0, 0, 4'b0100, "R2 inf>2");
        do_cmp(NINF, N2, 3'd1, 0, 0, 4'b1000, "R2 -inf<-2");
        do_cmp(P1, P1, 3'd2, 1, 0, 4'b0010, "R2 eq");
        check("R2 no flags", 64'({flag_snan, flag_vc}), 64'd0);
    endtask

    task automatic t_zero();
        do_cmp(PZ, NZ, 3'd2, 0, 0, 4'b0010, "R4 +0,-0");
        do_cmp(NZ, PZ, 3'd3, 1, 0, 4'b0010, "R4 -0,+0");
    endtask

    task automatic t_unordered_mode();
        do_cmp(QNAN, P1, 3'd1, 0, 0, 4'b0001, "R3 qnan");
        check("R7 qnan no flag", 64'({flag_snan, flag_vc}), 64'd0);
        do_cmp(P1, SNAN, 3'd6, 0, 0, 4'b0001, "R7 snan");
        check("R7 snan flag", 64'({flag_snan, flag_vc}), 64'b10);
    endtask

    task automatic t_clear_and_sticky();
        do_cmp(P1, P2, 3'd0, 0, 0, 4'b1000, "R9 sticky");
        check("R9 still set", 64'(flag_snan), 64'd1);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        check("R9 cleared", 64'({flag_snan, flag_vc}), 64'd0);
        check("R5 clear leaves cr", 64'(cond_reg), 64'(exp_cr));
        check("R10 no done", 64'(done), 64'd0);
    endtask

    task automatic t_ordered_mode();
        do_cmp(P1, QNAN, 3'd5, 1, 0, 4'b0001, "R8 qnan");
        check("R8 vc flag", 64'({flag_snan, flag_vc}), 64'b01);
        @(negedge clk); flag_clr = 1;
        @(negedge clk); flag_clr = 0;
        do_cmp(SNAN, QNAN, 3'd7, 1, 0, 4'b0001, "R8 snan");
        check("R8 snan flag only", 64'({flag_snan, flag_vc}), 64'b10);
    endtask

    task automatic t_collide();
        do_cmp(QNAN, QNAN, 3'd4, 1, 0, 4'b0001, "R8 setup");
        check("R9 both set", 64'({flag_snan, flag_vc}), 64'b11);
        do_cmp(QNAN, N1, 3'd0, 1, 1, 4'b0001, "R9 collide");
        check("R9 collide flags", 64'({flag_snan, flag_vc}), 64'b01);
    endtask

    task automatic t_idle();
        @(negedge clk);
        opa = P2; opb = P1; field_idx = 3'd3;
        repeat (3) @(negedge clk);
        check("R10 idle done", 64'(done), 64'd0);
        check("R5 idle cr", 64'(cond_reg), 64'(exp_cr));
    endtask

    initial begin
        #(PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_order();
        t_zero();
        t_unordered_mode();
        t_clear_and_sticky();
        t_ordered_mode();
        t_collide();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule